// File: doc/BRIEF.md
# Streaming Matrix Vertex Transform Engine

The engine applies a 3x4 affine matrix to vertices held in memory as separate x, y and z arrays. It serves five independent streams, and each stream has its own matrix in a shared file of 64 signed fixed-point coefficients. One tick starts a pass. A pass reads one vertex from every stream, plus the constant w word stored at a fixed address. For each output component it builds a four-term sum with a multiply-accumulate unit, and it stores the rounded-down, saturated results into output arrays that sit directly after the input arrays.

A pass always occupies a fixed frame of 128 slots. The schedule is one w load, then eighteen slots per stream: three loads, then three groups of four MACs each followed by a store. All slots after the last stream are idle. An internal vertex index picks which element of each array is used, and it advances by one after every pass.

Top module: `vxf_engine`

## Requirements
- R1: After reset, `busy` is low and no memory read or write is issued.
- R2: A `tick` seen while idle starts a pass. `busy` is then high for exactly 128 cycles, beginning with the cycle after the tick.
- R3: A `tick` that arrives while `busy` is high has no effect. The pass length, the number of stores and the vertex index are unchanged.
- R4: Each pass makes exactly 16 reads and 15 writes. One of the reads is at address `ONE_ADDR`, which holds the w value.
- R5: Let `k = s*12 + c*4`, where s is the stream (0..4) and c is the component (0 = x, 1 = y, 2 = z). Output component c of stream s is `sat((C[k]*x + C[k+1]*y + C[k+2]*z + C[k+3]*w) >>> FRAC)`. All values are signed two's complement, and the accumulator starts from zero for every component.
- R6: Results beyond the signed `DW`-bit range are clamped to the largest or smallest representable value.
- R7: The input word for stream s, component c is at `IN_BASE + (s*3+c)*NV + idx`. The output word is at the same offset plus `15*NV`. Stores are issued in stream order 0..4, and within each stream in the order x, y, z.
- R8: The vertex index `idx` starts at 0, increases by one after each pass, and wraps from `NV-1` to 0.
- R9: When `coefWe` is high, `coefData` is written into coefficient entry `coefAddr`. The new value is used by the next pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Start of a sample pass |
| busy | output | 1 | A pass is running |
| coefWe | input | 1 | Coefficient write enable |
| coefAddr | input | 6 | Coefficient entry index |
| coefData | input | DW | Coefficient value, FRAC fractional bits |
| memAddr | output | AW | Memory word address |
| memRe | output | 1 | Read strobe; data is expected one cycle later |
| memWe | output | 1 | Write strobe |
| memWdata | output | DW | Write data |
| memRdata | input | DW | Read data from a synchronous memory |

## Verification
The hardest case to reach is a tick that arrives in the middle of a pass. It has to be placed dozens of cycles after the accepted tick, while loads and stores are still in flight. The stimulus pulses `tick` again in slot 50 of one pass. It then confirms that the pass still lasts 128 cycles, makes 15 stores, and moves the vertex index by only one. Both saturation directions are forced in the same way: specific vertex slots are filled with large values and matched with extreme coefficients on the passes that land on those indices. Ten passes walk the index through its wrap.

// File: rtl/vxf_pkg.sv
package vxf_pkg;
  localparam int NCOEF = 64;
  localparam int NTERM = 4;

  typedef struct packed {
    logic       doLoad;
    logic [1:0] loadDst;
    logic       doMac;
    logic       macClr;
    logic [1:0] macSel;
    logic [5:0] coefIdx;
    logic       doStore;
  } vxfStrobe_t;
endpackage

// File: rtl/vxf_ctrl.sv
module vxf_ctrl
  import vxf_pkg::*;
#(
  parameter int AW       = 8,
  parameter int NV       = 8,
  parameter int NSTREAM  = 5,
  parameter int SLOTS    = 128,
  parameter int IN_BASE  = 0,
  parameter int ONE_ADDR = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic             busy,
  output logic [AW-1:0]    memAddr,
  output logic             memRe,
  output logic             memWe,
  output vxfStrobe_t       strobe
);
  localparam int OUT_BASE  = IN_BASE + NSTREAM * 3 * NV;
  localparam int PER_STRM  = 3 + 3 * (NTERM + 1);
  localparam int USED      = 1 + NSTREAM * PER_STRM;
  localparam int SW        = $clog2(SLOTS);
  localparam int IW        = (NV > 1) ? $clog2(NV) : 1;

  logic          busyQ;
  logic [SW-1:0] slotQ;
  logic [IW-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      slotQ <= '0;
      idxQ  <= '0;
    end else if (!busyQ) begin
      if (tick) begin
        busyQ <= 1'b1;
        slotQ <= '0;
      end
    end else begin
      slotQ <= slotQ + 1'b1;
      if (slotQ == SW'(SLOTS - 1)) begin
        busyQ <= 1'b0;
        idxQ  <= (idxQ == IW'(NV - 1)) ? '0 : idxQ + 1'b1;
      end
    end
  end

  int rel, strm, off, grp, comp, term, addr;

  always_comb begin
    strobe = '0;
    rel = 0; strm = 0; off = 0; grp = 0; comp = 0; term = 0;
    addr = 0;
    if (busyQ) begin
      if (slotQ == '0) begin
        strobe.doLoad  = 1'b1;
        strobe.loadDst = 2'd3;
        addr = ONE_ADDR;
      end else if (int'(slotQ) < USED) begin
        rel  = int'(slotQ) - 1;
        strm = rel / PER_STRM;
        off  = rel % PER_STRM;
        if (off < 3) begin
          strobe.doLoad  = 1'b1;
          strobe.loadDst = 2'(off);
          addr = IN_BASE + (strm * 3 + off) * NV + int'(idxQ);
        end else begin
          grp  = off - 3;
          comp = grp / (NTERM + 1);
          term = grp % (NTERM + 1);
          if (term < NTERM) begin
            strobe.doMac   = 1'b1;
            strobe.macClr  = (term == 0);
            strobe.macSel  = 2'(term);
            strobe.coefIdx = 6'(strm * 12 + comp * NTERM + term);
          end else begin
            strobe.doStore = 1'b1;
            addr = OUT_BASE + (strm * 3 + comp) * NV + int'(idxQ);
          end
        end
      end
    end
  end

  assign memAddr = AW'(addr);
  assign memRe   = strobe.doLoad;
  assign memWe   = strobe.doStore;
  assign busy    = busyQ;

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busyQ && slotQ != SW'(SLOTS - 1)) |=> (busyQ && slotQ == $past(slotQ) + 1'b1));
  p_store_in_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> (busyQ && !memRe));
  p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idxQ <= IW'(NV - 1));
  p_out_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> (memAddr >= AW'(OUT_BASE)));
endmodule

// File: rtl/vxf_datapath.sv
module vxf_datapath
  import vxf_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vxfStrobe_t    strobe,
  input  logic          coefWe,
  input  logic [5:0]    coefAddr,
  input  logic [DW-1:0] coefData,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memWdata
);
  localparam int ACCW = 2 * DW + 4;
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = -MAXV - 1;

  logic signed [DW-1:0]   coefQ [NCOEF];
  logic signed [DW-1:0]   xQ [NTERM];
  logic                   loadPendQ;
  logic [1:0]             loadDstQ;
  logic signed [ACCW-1:0] accQ;
  logic signed [2*DW-1:0] prod;
  logic signed [ACCW-1:0] prodExt;
  logic signed [ACCW-1:0] shifted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) coefQ[i] <= '0;
    end else if (coefWe) begin
      coefQ[coefAddr] <= coefData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loadPendQ <= 1'b0;
      loadDstQ  <= '0;
      for (int i = 0; i < NTERM; i++) xQ[i] <= '0;
    end else begin
      loadPendQ <= strobe.doLoad;
      loadDstQ  <= strobe.loadDst;
      if (loadPendQ) xQ[loadDstQ] <= memRdata;
    end
  end

  assign prod    = xQ[strobe.macSel] * coefQ[strobe.coefIdx];
  assign prodExt = prod;

  always_ff @(posedge clk) begin
    if (!rst_n)            accQ <= '0;
    else if (strobe.doMac) accQ <= (strobe.macClr ? '0 : accQ) + prodExt;
  end

  assign shifted = accQ >>> FRAC;

  always_comb begin
    if (shifted > MAXV)      memWdata = MAXV[DW-1:0];
    else if (shifted < MINV) memWdata = MINV[DW-1:0];
    else                     memWdata = shifted[DW-1:0];
  end

  p_acc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe.doMac) && $past(strobe.macClr)) |-> (accQ == $past(prodExt)));
  p_sat_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doStore |-> (memWdata[DW-1] == accQ[ACCW-1]));
endmodule

// File: rtl/vxf_engine.sv
module vxf_engine
  import vxf_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int FRAC     = 12,
  parameter int NV       = 8,
  parameter int IN_BASE  = 0,
  parameter int ONE_ADDR = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic          busy,
  input  logic          coefWe,
  input  logic [5:0]    coefAddr,
  input  logic [DW-1:0] coefData,
  output logic [AW-1:0] memAddr,
  output logic          memRe,
  output logic          memWe,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata
);
  vxfStrobe_t strobe;

  vxf_ctrl #(.AW(AW), .NV(NV), .NSTREAM(5), .SLOTS(128),
             .IN_BASE(IN_BASE), .ONE_ADDR(ONE_ADDR)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe), .strobe(strobe)
  );

  vxf_datapath #(.DW(DW), .FRAC(FRAC)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .memRdata(memRdata), .memWdata(memWdata)
  );
endmodule

// File: tb/vxf_engine_tb.sv
module vxf_engine_tb_top;
  localparam int NV = 8;
  localparam int ONE = 255;
  localparam int OUTB = 15 * NV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic busy;
  logic coefWe = 1'b0;
  logic [5:0] coefAddr = '0;
  logic [15:0] coefData = '0;
  logic [7:0] memAddr;
  logic memRe, memWe;
  logic [15:0] memWdata;
  logic [15:0] memRdata;

  logic [15:0] mem [256];
  int coefM [64];
  int expAddr [$];
  int expData [$];
  int checks = 0, errors = 0;
  int idx = 0, oneReads = 0, reads = 0;
  int seed = 12345;

  always #5 clk = ~clk;

  vxf_engine dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R5, R7: store order and values compared every clock a write appears
  always @(negedge clk) begin
    if (memRe) begin
      reads++;
      if (memAddr == 8'(ONE)) oneReads++;
    end
    if (memWe) begin
      if (expAddr.size() == 0) chk(0, "R4 extra store", int'(memAddr), -1);
      else begin
        chk(int'(memAddr) == expAddr[0], "R7 store address", int'(memAddr), expAddr[0]);
        chk(int'($signed(memWdata)) == expData[0], "R5/R6 store data",
            int'($signed(memWdata)), expData[0]);
        void'(expAddr.pop_front());
        void'(expData.pop_front());
      end
    end
  end

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'hFFFF;
  endfunction

  task automatic setCoef(input int i, input int v);
    @(negedge clk);
    coefWe = 1'b1; coefAddr = 6'(i); coefData = 16'(v);
    coefM[i] = int'($signed(16'(v)));
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  task automatic buildExpect();
    for (int s = 0; s < 5; s++)
      for (int c = 0; c < 3; c++) begin
        longint acc = 0;
        longint sh;
        int k = s * 12 + c * 4;
        for (int j = 0; j < 3; j++)
          acc += longint'(coefM[k + j]) * longint'($signed(mem[(s * 3 + j) * NV + idx]));
        acc += longint'(coefM[k + 3]) * longint'($signed(mem[ONE]));
        sh = acc >>> 12;
        if (sh > 32767) sh = 32767;
        if (sh < -32768) sh = -32768;
        expAddr.push_back(OUTB + (s * 3 + c) * NV + idx);
        expData.push_back(int'(sh));
      end
  endtask

  task automatic runPass(input bit poke);
    int cnt = 0;
    reads = 0; oneReads = 0;
    buildExpect();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    while (busy && cnt < 400) begin
      tick = (poke && cnt == 50);  // R3 tick during pass
      cnt++;
      @(negedge clk);
    end
    tick = 1'b0;
    chk(cnt == 128, poke ? "R3 pass length with extra tick" : "R2 pass length", cnt, 128);
    chk(expAddr.size() == 0, "R4 missing stores", expAddr.size(), 0);
    chk(reads == 16, "R4 read count", reads, 16);
    chk(oneReads == 1, "R4 w read", oneReads, 1);
    expAddr.delete(); expData.delete();
    idx = (idx == NV - 1) ? 0 : idx + 1;  // R8 wrap
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R3 no restart after pass", int'(busy), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(nextRand() % 4000 - 2000);
    for (int s = 0; s < 15; s++) begin
      mem[s * NV + 3] = 16'(20000);
      mem[s * NV + 4] = 16'(20000);
    end
    mem[ONE] = 16'(1);
    for (int i = 0; i < 64; i++) coefM[i] = 0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && memWe == 1'b0 && memRe == 1'b0, "R1 reset idle", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && memWe == 1'b0, "R1 idle after reset", int'(busy), 0);

    // R9 identity matrices with a translation per stream
    for (int s = 0; s < 5; s++)
      for (int c = 0; c < 3; c++) begin
        setCoef(s * 12 + c * 4 + c, 4096);
        setCoef(s * 12 + c * 4 + 3, 4096 * (s + 1));
      end
    for (int p = 0; p < 10; p++) begin
      if (p == 1 || p == 5 || p == 8)
        for (int i = 0; i < 60; i++) setCoef(i, nextRand() % 16384 - 8192);
      if (p == 3) for (int i = 0; i < 60; i++) setCoef(i, 16'h7FFF);  // R6 high
      if (p == 4) for (int i = 0; i < 60; i++) setCoef(i, 16'h8000);  // R6 low
      if (p == 6) mem[ONE] = 16'(2);                                  // R5 w from memory
      runPass(p == 2 || p == 7);
    end
    chk(idx == 2, "R8 index after wrap", idx, 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule